// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a true dual-port synchronous RAM of 2^ADDR_W words (8K by default, 13-bit addresses) of DATA_W bits (8 or 9). There are two ports, side A and side B. Each has an enable, a write strobe, a read-output enable, an address, write data and registered read data. Any number of reads of the same word can happen at once. Ordinary words behave as plain storage.

The two highest addresses are mailboxes for messages between the sides. The word at the all-ones address belongs to side B, and the word one below it belongs to side A. When one side writes into the other side's mailbox, the owner gets an interrupt on its active-low interrupt output. The owner acknowledges by reading its own mailbox, and that read also returns the stored message word.

When both sides write the same word in one cycle, side A's write wins. Callers are expected to arbitrate such conflicts themselves.

Top module: `mbox_dpram`

## Requirements
- R1: A write is an access with en=1 and we=1. A read is an access with en=1, we=0 and oe=1. A read returns the stored word on rdata in the cycle after the access, for any address.
- R2: Both sides reading one address in the same cycle both receive the same stored word.
- R3: A side-A write to address 2^ADDR_W-1 (all ones) drives b_irq_n low from the next cycle on.
- R4: A side-B read of address 2^ADDR_W-1 drives b_irq_n high from the next cycle, and returns the word side A wrote there.
- R5: A side-B write to address 2^ADDR_W-2 drives a_irq_n low from the next cycle on.
- R6: A side-A read of address 2^ADDR_W-2 drives a_irq_n high from the next cycle, and returns the word side B wrote there.
- R7: An access with en=0, or with we=0 and oe=0, neither reads nor clears an interrupt, and leaves that side's rdata unchanged. An access with en=0 and we=1 writes nothing.
- R8: If an interrupt is set and cleared in the same cycle, it ends up asserted (low).
- R9: During and right after reset, a_irq_n and b_irq_n are high and both rdata outputs are zero.
- R10: A side's write to its own mailbox, and its read of the other side's mailbox, change neither interrupt.
- R11: A read of a word that the other side writes in the same cycle returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Side A access enable |
| a_we | input | 1 | Side A write strobe |
| a_oe | input | 1 | Side A read-output enable |
| a_addr | input | ADDR_W | Side A word address |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A registered read data |
| a_irq_n | output | 1 | Side A interrupt, active low |
| b_en | input | 1 | Side B access enable |
| b_we | input | 1 | Side B write strobe |
| b_oe | input | 1 | Side B read-output enable |
| b_addr | input | ADDR_W | Side B word address |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B registered read data |
| b_irq_n | output | 1 | Side B interrupt, active low |

## Verification
The assertions check on every cycle:
- a mailbox write at the ports lowers the peer's interrupt in the next cycle;
- each interrupt flag obeys set, clear, set-over-clear and hold;
- rdata stays stable when no read takes place;
- both interrupts come out of reset deasserted.

Data values can only be shown by the bench's scenarios, because they depend on earlier writes. These are:
- the message word read back from a mailbox;
- old data returned when a read and a write hit the same word;
- reads of one word by both sides;
- accesses without a read or with enable off, which change nothing.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int SIDES = 2;

  // an access is a read only when enabled, not writing and output enabled
  function automatic logic is_read(input logic en, input logic we, input logic oe);
    return en & ~we & oe;
  endfunction

  function automatic logic is_write(input logic en, input logic we);
    return en & we;
  endfunction

  // mailbox word owned by a side: side 1 owns the top word, side 0 the one below
  function automatic int unsigned box_loc(input int aw, input int side);
    return ((32'd1 << aw) - 32'd1) - 32'(SIDES - 1 - side);
  endfunction

endpackage

// File: rtl/mbox_side_decode.sv
module mbox_side_decode #(
  parameter int ADDR_W = 13,
  parameter int SIDE   = 0
) (
  input  logic              en,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic              peer_box_wr,
  output logic              own_box_rd
);
  localparam logic [ADDR_W-1:0] OWN_BOX  = ADDR_W'(mbox_pkg::box_loc(ADDR_W, SIDE));
  localparam logic [ADDR_W-1:0] PEER_BOX = ADDR_W'(mbox_pkg::box_loc(ADDR_W, 1 - SIDE));

  assign wr_stb      = mbox_pkg::is_write(en, we);
  assign rd_stb      = mbox_pkg::is_read(en, we, oe);
  assign peer_box_wr = wr_stb && (addr == PEER_BOX);
  assign own_box_rd  = rd_stb && (addr == OWN_BOX);
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq_n
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (clr_evt) pend_q <= 1'b0;
  end

  assign irq_n = ~pend_q;

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> !irq_n);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_evt) |=> !irq_n);
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> irq_n);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !clr_evt) |=> $stable(irq_n));
endmodule

// File: rtl/mbox_mem.sv
module mbox_mem #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr     [mbox_pkg::SIDES],
  input  logic              rd     [mbox_pkg::SIDES],
  input  logic [ADDR_W-1:0] addr   [mbox_pkg::SIDES],
  input  logic [DATA_W-1:0] wdata  [mbox_pkg::SIDES],
  output logic [DATA_W-1:0] rdata  [mbox_pkg::SIDES]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // side 0 is applied last so it wins a same-word write collision
  always_ff @(posedge clk) begin
    for (int p = mbox_pkg::SIDES - 1; p >= 0; p--) begin
      if (wr[p]) cells[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < mbox_pkg::SIDES; p++) begin : g_rport
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata[p] <= '0;
      else if (rd[p]) rdata[p] <= cells[addr[p]];
    end

    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd[p] |=> $stable(rdata[p]));
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic              a_oe,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq_n,
  input  logic              b_en,
  input  logic              b_we,
  input  logic              b_oe,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq_n
);
  localparam int NS = mbox_pkg::SIDES;
  localparam logic [ADDR_W-1:0] BOX_A = ADDR_W'(mbox_pkg::box_loc(ADDR_W, 0));
  localparam logic [ADDR_W-1:0] BOX_B = ADDR_W'(mbox_pkg::box_loc(ADDR_W, 1));

  logic              s_en   [NS];
  logic              s_we   [NS];
  logic              s_oe   [NS];
  logic [ADDR_W-1:0] s_addr [NS];
  logic [DATA_W-1:0] s_wd   [NS];
  logic [DATA_W-1:0] s_rd   [NS];
  logic              wr_stb [NS];
  logic              rd_stb [NS];
  logic              peer_wr[NS];
  logic              own_rd [NS];
  logic              irq_n  [NS];

  assign s_en[0] = a_en;   assign s_en[1] = b_en;
  assign s_we[0] = a_we;   assign s_we[1] = b_we;
  assign s_oe[0] = a_oe;   assign s_oe[1] = b_oe;
  assign s_addr[0] = a_addr;  assign s_addr[1] = b_addr;
  assign s_wd[0] = a_wdata;   assign s_wd[1] = b_wdata;

  for (genvar s = 0; s < NS; s++) begin : g_side
    mbox_side_decode #(.ADDR_W(ADDR_W), .SIDE(s)) u_dec (
      .en(s_en[s]), .we(s_we[s]), .oe(s_oe[s]), .addr(s_addr[s]),
      .wr_stb(wr_stb[s]), .rd_stb(rd_stb[s]),
      .peer_box_wr(peer_wr[s]), .own_box_rd(own_rd[s])
    );

    // set by the other side's write to this mailbox, cleared by own read
    mbox_irq_flag u_irq (
      .clk(clk), .rst_n(rst_n),
      .set_evt(peer_wr[NS-1-s]), .clr_evt(own_rd[s]),
      .irq_n(irq_n[s])
    );
  end

  mbox_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_stb), .rd(rd_stb), .addr(s_addr), .wdata(s_wd), .rdata(s_rd)
  );

  assign a_rdata = s_rd[0];
  assign b_rdata = s_rd[1];
  assign a_irq_n = irq_n[0];
  assign b_irq_n = irq_n[1];

  assert_a_sets_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we && a_addr == BOX_B) |=> !b_irq_n);
  assert_b_sets_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && b_we && b_addr == BOX_A) |=> !a_irq_n);
  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (a_irq_n && b_irq_n));
endmodule

// File: tb/mbox_dpram_tb.sv
module mbox_dpram_tb;
  localparam int AW = 13;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en = 0, a_we = 0, a_oe = 0, b_en = 0, b_we = 0, b_oe = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_irq_n, b_irq_n;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq_n(a_irq_n),
    .b_en(b_en), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq_n(b_irq_n)
  );

  typedef struct packed {
    logic a_en, a_we, a_oe; logic [12:0] a_addr; logic [7:0] a_wd;
    logic b_en, b_we, b_oe; logic [12:0] b_addr; logic [7:0] b_wd;
    logic [7:0] ex_a, ex_b; logic ex_ai, ex_bi; logic [3:0] req;
  } vec_t;

  // A box = 1FFE, B box = 1FFF; outputs checked one cycle after each access
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1,1,0,13'h0010,8'h5A, 1,1,0,13'h0020,8'hA5, 8'h00,8'h00,1,1,4'd1},  // R1 writes
    '{1,0,1,13'h0020,8'h00, 1,0,1,13'h0010,8'h00, 8'hA5,8'h5A,1,1,4'd1},  // R1 cross reads
    '{1,0,1,13'h0010,8'h00, 1,0,1,13'h0010,8'h00, 8'h5A,8'h5A,1,1,4'd2},  // R2 same word
    '{1,1,0,13'h1FFF,8'h3C, 0,0,0,13'h0000,8'h00, 8'h5A,8'h5A,1,0,4'd3},  // R3 set B
    '{0,0,0,13'h0000,8'h00, 1,0,0,13'h1FFF,8'h00, 8'h5A,8'h5A,1,0,4'd7},  // R7 no oe
    '{0,0,0,13'h0000,8'h00, 1,0,1,13'h1FFF,8'h00, 8'h5A,8'h3C,1,1,4'd4},  // R4 clear B
    '{0,0,0,13'h0000,8'h00, 1,1,0,13'h1FFE,8'hC3, 8'h5A,8'h3C,0,1,4'd5},  // R5 set A
    '{1,0,1,13'h1FFF,8'h00, 0,0,0,13'h0000,8'h00, 8'h3C,8'h3C,0,1,4'd10}, // R10 A reads B box
    '{0,0,1,13'h1FFE,8'h00, 0,0,0,13'h0000,8'h00, 8'h3C,8'h3C,0,1,4'd7},  // R7 en off
    '{1,0,1,13'h1FFE,8'h00, 0,0,0,13'h0000,8'h00, 8'hC3,8'h3C,1,1,4'd6},  // R6 clear A
    '{1,1,0,13'h1FFE,8'h77, 0,0,0,13'h0000,8'h00, 8'hC3,8'h3C,1,1,4'd10}, // R10 own box write
    '{0,0,0,13'h0000,8'h00, 1,0,1,13'h1FFE,8'h00, 8'hC3,8'h77,1,1,4'd10}, // R10 B reads A box
    '{1,1,0,13'h1FFF,8'h11, 0,0,0,13'h0000,8'h00, 8'hC3,8'h77,1,0,4'd3},  // R3 set B again
    '{1,1,0,13'h1FFF,8'h22, 1,0,1,13'h1FFF,8'h00, 8'hC3,8'h11,1,0,4'd8},  // R8 set beats clear
    '{0,0,0,13'h0000,8'h00, 1,0,1,13'h1FFF,8'h00, 8'hC3,8'h22,1,1,4'd4},  // R4 new word
    '{1,1,0,13'h0010,8'h66, 1,0,1,13'h0010,8'h00, 8'hC3,8'h5A,1,1,4'd11}, // R11 old data
    '{0,0,0,13'h0000,8'h00, 1,0,1,13'h0010,8'h00, 8'hC3,8'h66,1,1,4'd1},  // R1 new data
    '{0,1,0,13'h0010,8'h00, 0,0,0,13'h0000,8'h00, 8'hC3,8'h66,1,1,4'd7},  // R7 write w/o en
    '{1,0,1,13'h0010,8'h00, 0,0,0,13'h0000,8'h00, 8'h66,8'h66,1,1,4'd7}   // R7 word kept
  };

  task automatic check(input string req, input logic [7:0] ea, input logic [7:0] eb,
                       input logic eai, input logic ebi);
    n_run++;
    if (a_rdata !== ea || b_rdata !== eb || a_irq_n !== eai || b_irq_n !== ebi) begin
      n_fail++;
      $display("FAIL %s: got a_rd=%h b_rd=%h a_irq_n=%b b_irq_n=%b, want %h %h %b %b",
               req, a_rdata, b_rdata, a_irq_n, b_irq_n, ea, eb, eai, ebi);
    end
  endtask

  task automatic drive(input vec_t v);
    a_en = v.a_en; a_we = v.a_we; a_oe = v.a_oe; a_addr = v.a_addr; a_wdata = v.a_wd;
    b_en = v.b_en; b_we = v.b_we; b_oe = v.b_oe; b_addr = v.b_addr; b_wdata = v.b_wd;
  endtask

  task automatic idle();
    a_en = 0; a_we = 0; a_oe = 0; b_en = 0; b_we = 0; b_oe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 in reset", 8'h00, 8'h00, 1'b1, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", 8'h00, 8'h00, 1'b1, 1'b1);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].ex_a, VECS[i].ex_b, VECS[i].ex_ai, VECS[i].ex_bi);
    end

    // both interrupts set in one cycle (R3, R5), then reset clears them (R9)
    a_en = 1; a_we = 1; a_addr = 13'h1FFF; a_wdata = 8'h01;
    b_en = 1; b_we = 1; b_oe = 0; b_addr = 13'h1FFE; b_wdata = 8'h02;
    @(negedge clk);
    check("R3 R5 both set", 8'h66, 8'h66, 1'b0, 1'b0);
    idle();
    @(negedge clk);
    check("R10 idle hold", 8'h66, 8'h66, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R9 async reset", 8'h00, 8'h00, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 released", 8'h00, 8'h00, 1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule